// File: doc/BRIEF.md
# Buffered UART Transmitter with Idle Preamble

This block is an asynchronous serial transmitter with a single character of buffering. A processor writes characters through a small register interface: a control register, a status register, a write-only low data register, and a ninth-bit register. A shift register behind the buffer drives the serial line. Each bit lasts sixteen pulses of an external baud tick. Characters carry 8 or 9 data bits. Optional odd or even parity replaces the top data bit; it does not add a bit.

When the transmitter is switched on, it first sends a full frame length of idle ones. Only after that does the buffered character go out. An "empty" flag tells software when the buffer can accept the next character. An interrupt output follows that flag when enabled.

The empty flag clears only through a handshake: a status read while the flag is set, followed by a write of the low data register. Register writes never stall. The strobes have no back-pressure, so software must follow the empty flag itself. When a character is waiting at the end of a stop bit, it is loaded in that same cycle, so consecutive frames have no gap between them.

Top module: `uart_txbuf`

## Requirements
- R1: After reset the serial line `txd` is 1, the empty flag is 1, and `irq` is 0.
- R2: While the enable bit is 0, no frame starts and `txd` stays 1. A buffered character stays buffered, so the empty flag remains 0.
- R3: A 0-to-1 change of the enable bit first shifts out idle ones for one frame length: 10 bit times in 8-bit mode, 11 in 9-bit mode. The buffered character starts after that.
- R4: A frame is a 0 start bit, then the data bits LSB first, then a 1 stop bit. Each bit lasts 16 baud ticks.
- R5: With the nine-bit mode bit set, the ninth data bit (bit 8) is taken from bit 0 of the ninth-bit register at address 3.
- R6: With parity enabled, the top data bit (bit 7 in 8-bit mode, bit 8 in 9-bit mode) is replaced by a parity bit over the remaining data bits. The parity bit gives an even total of ones when the odd-parity bit is 0, and an odd total when it is 1.
- R7: The empty flag sets in the cycle the buffered character moves into the shift register.
- R8: The empty flag clears only when a status read that sees the flag set is followed by a write to the low data register. A write to that register with no such read leaves the flag at 1 and starts nothing.
- R9: `irq` is 1 exactly when the interrupt-enable bit and the empty flag are both 1.
- R10: A character that is waiting when a stop bit ends is loaded at once. Start bits of consecutive frames are exactly one frame length apart (10 or 11 times 16 ticks).
- R11: If the enable bit is cleared during a frame, that frame completes, and then the line stays idle.
- R12: Register map on `addr`:
  - Address 0 is control and reads back. Bit 0 is enable, bit 1 is interrupt enable, bit 2 is nine-bit mode, bit 3 is parity enable, and bit 4 selects odd parity.
  - Address 1 is status. The empty flag is in bit 0.
  - Address 2 is the low data register, write only.
  - Address 3 is the ninth-bit register, write only. The ninth bit is in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of `rd_en` |
| txd | output | 1 | Serial output, idle high |
| irq | output | 1 | Buffer-empty interrupt request |

## Verification
Two functions can land in the same clock edge: the end of a stop bit, and the transfer of the next waiting character into the shift register (which also sets the empty flag). The bench provokes this by writing the next character while the current frame is still shifting. It does the same for a frame still pending behind the enable preamble. It judges the result by two things: the distance between successive start edges must be exactly one frame length, and each decoded frame must match the scoreboard entry. A late or early reload would shift the start edge or corrupt the leading bits of the next frame.

// File: rtl/uart_txbuf_pkg.sv
package uart_txbuf_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DLO  = 2'd2;
  localparam logic [ADDR_W-1:0] A_DHI  = 2'd3;

  // bit 0 is the enable, bit 4 the odd-parity select
  typedef struct packed {
    logic par_odd;
    logic par_en;
    logic nine;
    logic tie;
    logic ten;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/uart_txbuf_regs.sv
module uart_txbuf_regs
  import uart_txbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              load_data,
  output ctrl_t             ctrl_q,
  output logic [DATA_W-1:0] dlo_q,
  output logic              dhi_q,
  output logic              empty_q,
  output logic [DATA_W-1:0] rdata
);
  logic armed_q;
  logic lo_wr, stat_rd;

  assign lo_wr   = wr_en && (addr == A_DLO);
  assign stat_rd = rd_en && (addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      dlo_q   <= '0;
      dhi_q   <= 1'b0;
      empty_q <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      if (wr_en && addr == A_CTRL) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr_en && addr == A_DHI)  dhi_q  <= wdata[0];
      if (lo_wr)                   dlo_q  <= wdata;
      // load happens only while full, the clear only while empty
      if (load_data)               empty_q <= 1'b1;
      else if (lo_wr && armed_q)   empty_q <= 1'b0;
      if (lo_wr)                   armed_q <= 1'b0;
      else if (stat_rd && empty_q) armed_q <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CTRL:  rdata[CTRL_W-1:0] = ctrl_q;
        A_STAT:  rdata[0] = empty_q;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_txbuf_framer.sv
module uart_txbuf_framer
  import uart_txbuf_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 3,
  parameter int CNT_W   = 4
) (
  input  logic [DATA_W-1:0]  dlo,
  input  logic               dhi,
  input  ctrl_t              ctrl,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   len
);
  logic [DATA_W-1:0] lo_body;
  logic              hi_body;

  always_comb begin
    lo_body = dlo;
    hi_body = dhi;
    if (ctrl.nine) begin
      if (ctrl.par_en) hi_body = (^dlo) ^ ctrl.par_odd;
      frame = {1'b1, hi_body, lo_body, 1'b0};
      len   = CNT_W'(DATA_W + 3);
    end else begin
      if (ctrl.par_en) lo_body[DATA_W-1] = (^dlo[DATA_W-2:0]) ^ ctrl.par_odd;
      frame = {2'b11, lo_body, 1'b0};
      len   = CNT_W'(DATA_W + 2);
    end
  end
endmodule

// File: rtl/uart_txbuf_shifter.sv
module uart_txbuf_shifter #(
  parameter int FRAME_W    = 11,
  parameter int OVERSAMPLE = 16,
  parameter int CNT_W      = 4,
  localparam int SUB_W     = $clog2(OVERSAMPLE)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               baud_tick,
  input  logic               ten,
  input  logic               has_data,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   len,
  output logic               load_data,
  output logic               busy,
  output logic               frame_end,
  output logic               txd
);
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   left_q;
  logic [SUB_W-1:0]   sub_q;
  logic               busy_q, ten_q, pre_pend_q;
  logic               bit_end, can_start, start_pre, te_rise;

  assign te_rise   = ten && !ten_q;
  assign bit_end   = busy_q && baud_tick && (sub_q == SUB_W'(OVERSAMPLE - 1));
  assign frame_end = bit_end && (left_q == CNT_W'(1));
  assign can_start = ten && (!busy_q || frame_end);
  assign start_pre = can_start && (te_rise || pre_pend_q);
  assign load_data = can_start && !start_pre && has_data;
  assign busy      = busy_q;
  assign txd       = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= '1;
      left_q     <= '0;
      sub_q      <= '0;
      busy_q     <= 1'b0;
      ten_q      <= 1'b0;
      pre_pend_q <= 1'b0;
    end else begin
      ten_q      <= ten;
      pre_pend_q <= start_pre ? 1'b0 : (pre_pend_q || te_rise);
      if (start_pre) begin
        sh_q   <= '1;
        left_q <= len;
        sub_q  <= '0;
        busy_q <= 1'b1;
      end else if (load_data) begin
        sh_q   <= frame;
        left_q <= len;
        sub_q  <= '0;
        busy_q <= 1'b1;
      end else if (bit_end) begin
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - CNT_W'(1);
        sub_q  <= '0;
        if (left_q == CNT_W'(1)) busy_q <= 1'b0;
      end else if (busy_q && baud_tick) begin
        sub_q  <= sub_q + SUB_W'(1);
      end
    end
  end
endmodule

// File: rtl/uart_txbuf.sv
module uart_txbuf
  import uart_txbuf_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              txd,
  output logic              irq
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  ctrl_t              ctrl_q;
  logic [DATA_W-1:0]  dlo_q;
  logic               dhi_q, empty_q, load_data, busy, frame_end;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   len;

  uart_txbuf_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .load_data(load_data), .ctrl_q(ctrl_q), .dlo_q(dlo_q),
    .dhi_q(dhi_q), .empty_q(empty_q), .rdata(rdata)
  );

  uart_txbuf_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
    .dlo(dlo_q), .dhi(dhi_q), .ctrl(ctrl_q), .frame(frame), .len(len)
  );

  uart_txbuf_shifter #(.FRAME_W(FRAME_W), .OVERSAMPLE(OVERSAMPLE), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .ten(ctrl_q.ten),
    .has_data(!empty_q), .frame(frame), .len(len), .load_data(load_data),
    .busy(busy), .frame_end(frame_end), .txd(txd)
  );

  assign irq = ctrl_q.tie && empty_q;
endmodule

// File: rtl/uart_txbuf_checker.sv
module uart_txbuf_checker
  import uart_txbuf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              txd,
  input logic              irq,
  input logic              empty,
  input logic              load_data,
  input logic              busy,
  input logic              frame_end,
  input logic              ten
);
  a_r7_empty_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_data |=> empty);

  a_r8_load_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    load_data |-> !empty);

  a_r8_clear_by_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(empty) |-> $past(wr_en && addr == A_DLO));

  a_r9_irq_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> !irq);

  a_r2_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ten) |=> !busy);

  a_r4_stop_bit_high: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> txd);
endmodule

bind uart_txbuf uart_txbuf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .txd(txd), .irq(irq),
  .empty(empty_q), .load_data(load_data), .busy(busy), .frame_end(frame_end),
  .ten(ctrl_q.ten)
);

// File: tb/uart_txbuf_bench.sv
module uart_txbuf_bench;
  localparam int CLK_P   = 10;
  localparam int BIT_CLK = 32;  // 16 ticks, one tick every 2 clocks

  logic clk = 0, rst_n = 0, baud_tick = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic txd, irq;

  int cyc = 0, n_chk = 0, n_fail = 0, n_push = 0, n_done = 0;
  logic b_nine = 0, b_pe = 0, b_pt = 0;

  typedef struct {
    logic [10:0] bits;
    int          len;
    string       tag;
  } item_t;
  item_t q[$];
  int starts[$];

  uart_txbuf u_uart_txbuf (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .txd(txd), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  initial forever begin
    @(negedge clk);
    baud_tick = ~baud_tick;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_frame(input logic [7:0] d, input logic h);
    logic [8:0] body;
    if (b_nine) begin
      body = {h, d};
      if (b_pe) body[8] = (^d) ^ b_pt;
      return {1'b1, body, 1'b0};
    end
    body = {1'b0, d};
    if (b_pe) body[7] = (^d[6:0]) ^ b_pt;
    return {2'b11, body[7:0], 1'b0};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1; addr = a;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic set_ctrl(input logic te, tie, nine, pe, pt);
    b_nine = nine; b_pe = pe; b_pt = pt;
    wr(2'd0, {3'b0, pt, pe, nine, tie, te});
  endtask

  task automatic push_exp(input logic [7:0] d, input logic h, input string tag);
    item_t it;
    it.bits = exp_frame(d, h);
    it.len  = b_nine ? 11 : 10;
    it.tag  = tag;
    q.push_back(it);
    n_push++;
  endtask

  // driver: wait for the empty flag (read arms the handshake), then write
  task automatic send(input logic [7:0] d, input logic h, input string tag);
    logic [7:0] s;
    int g = 0;
    do begin
      rd(2'd1, s);
      g++;
    end while (s[0] !== 1'b1 && g < 20000);
    if (b_nine) wr(2'd3, {7'b0, h});
    wr(2'd2, d);
    push_exp(d, h, tag);
  endtask

  task automatic wait_idle();
    int g = 0;
    while (n_done != n_push && g < 40000) begin
      @(negedge clk);
      g++;
    end
    repeat (40) @(negedge clk);
  endtask

  task automatic wait_starts(input int n);
    int g = 0;
    while (starts.size() < n && g < 20000) begin
      @(negedge clk);
      g++;
    end
  endtask

  // monitor: decode frames on txd and compare with the scoreboard
  initial begin
    item_t it;
    logic [10:0] got, mask;
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        starts.push_back(cyc);
        if (q.size() == 0) begin
          chk(0, "R2 unexpected frame start", 0, 1);
          repeat (BIT_CLK * 11) @(negedge clk);
        end else begin
          it = q.pop_front();
          got = '1;
          repeat (BIT_CLK/2) @(negedge clk);
          for (int i = 0; i < it.len; i++) begin
            got[i] = txd;
            if (i < it.len - 1) repeat (BIT_CLK) @(negedge clk);
          end
          mask = (11'h1 << it.len) - 11'h1;
          chk(((got ^ it.bits) & mask) == 0, {it.tag, " R4 frame content"},
              int'(got & mask), int'(it.bits & mask));
          n_done++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", n_done, n_push);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int c0, s0, d, bad;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(txd === 1'b1, "R1 txd idle after reset", txd, 1);
    chk(irq === 1'b0, "R1 irq low after reset", irq, 0);

    // R8: lone data write without a prior status read
    wr(2'd2, 8'hEE);
    rd(2'd1, v);
    chk(v[0] === 1'b1, "R1 R8 empty still set after lone write", v[0], 1);
    wr(2'd2, 8'h5A);
    push_exp(8'h5A, 1'b0, "R3");
    rd(2'd1, v);
    chk(v[0] === 1'b0, "R8 empty cleared by read then write", v[0], 0);

    // R2: disabled transmitter holds the line
    bad = 0;
    repeat (400) begin
      @(negedge clk);
      if (txd !== 1'b1) bad++;
    end
    chk(bad == 0, "R2 line high while disabled", bad, 0);
    chk(starts.size() == 0, "R2 no frame while disabled", starts.size(), 0);
    rd(2'd1, v);
    chk(v[0] === 1'b0, "R2 character stays buffered", v[0], 0);
    rd(2'd0, v);
    chk(v == 8'h00, "R12 control reads back", v, 0);

    // R3: enable with 8-bit frames, preamble of 10 bit times
    set_ctrl(1, 1, 0, 0, 0);
    c0 = cyc;
    wait_starts(1);
    d = (starts.size() > 0) ? starts[0] - c0 : -1;
    chk(d >= 10*BIT_CLK - 3 && d <= 10*BIT_CLK + 4, "R3 preamble 10 bits", d, 10*BIT_CLK);
    repeat (2) @(negedge clk);
    chk(irq === 1'b1, "R9 irq with enable and empty", irq, 1);
    rd(2'd1, v);
    chk(v[0] === 1'b1, "R7 empty set on transfer", v[0], 1);
    rd(2'd0, v);
    chk(v == 8'h03, "R12 control reads back", v, 3);

    // R10: back-to-back frames
    send(8'hA5, 1'b0, "R10");
    send(8'h3C, 1'b0, "R10");
    @(negedge clk);
    chk(irq === 1'b0, "R9 irq low while buffer full", irq, 0);
    wait_idle();
    d = (starts.size() > 2) ? starts[1] - starts[0] : -1;
    chk(d >= 10*BIT_CLK - 1 && d <= 10*BIT_CLK + 1, "R10 no gap first pair", d, 10*BIT_CLK);
    d = (starts.size() > 2) ? starts[2] - starts[1] : -1;
    chk(d >= 10*BIT_CLK - 1 && d <= 10*BIT_CLK + 1, "R10 no gap second pair", d, 10*BIT_CLK);

    // R6: 8-bit parity even, then odd
    set_ctrl(1, 1, 0, 1, 0);
    send(8'h7F, 1'b0, "R6");
    send(8'h01, 1'b0, "R6");
    wait_idle();
    set_ctrl(1, 1, 0, 1, 1);
    send(8'h7F, 1'b0, "R6");
    send(8'h80, 1'b0, "R6");
    wait_idle();

    // R3/R5: 9-bit mode, preamble of 11 bit times
    set_ctrl(0, 0, 0, 0, 0);
    repeat (40) @(negedge clk);
    set_ctrl(0, 0, 1, 0, 0);
    send(8'h96, 1'b1, "R5");
    s0 = starts.size();
    set_ctrl(1, 0, 1, 0, 0);
    c0 = cyc;
    wait_starts(s0 + 1);
    d = (starts.size() > s0) ? starts[s0] - c0 : -1;
    chk(d >= 11*BIT_CLK - 3 && d <= 11*BIT_CLK + 4, "R3 preamble 11 bits", d, 11*BIT_CLK);
    send(8'h00, 1'b1, "R5");
    send(8'hFF, 1'b0, "R5");
    wait_idle();
    set_ctrl(1, 0, 1, 1, 0);
    send(8'h0F, 1'b0, "R6");
    send(8'h01, 1'b1, "R6");
    wait_idle();
    set_ctrl(1, 0, 1, 1, 1);
    send(8'h03, 1'b1, "R6");
    wait_idle();

    // R11: disable in the middle of a frame
    set_ctrl(1, 0, 0, 0, 0);
    s0 = starts.size();
    send(8'hC3, 1'b0, "R11");
    wait_starts(s0 + 1);
    repeat (100) @(negedge clk);
    set_ctrl(0, 0, 0, 0, 0);
    send(8'h81, 1'b0, "R11");
    c0 = 0;
    while (n_done != n_push - 1 && c0 < 20000) begin
      @(negedge clk);
      c0++;
    end
    bad = 0;
    repeat (700) begin
      @(negedge clk);
      if (txd !== 1'b1) bad++;
    end
    chk(bad == 0, "R11 line idle after finished frame", bad, 0);
    chk(starts.size() == s0 + 1, "R11 no new frame after disable", starts.size(), s0 + 1);
    rd(2'd1, v);
    chk(v[0] === 1'b0, "R11 R2 next character held", v[0], 0);
    set_ctrl(1, 0, 0, 0, 0);
    wait_idle();

    chk(q.size() == 0 && n_done == n_push, "R4 every frame observed", n_done, n_push);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule